// File: doc/BRIEF.md
# SCCB Register Bridge

This block lets a host program an image sensor over a two-wire SCCB link through a small byte-wide register window. The host first loads an enable byte, the sensor's 8-bit write address and the index and data bytes. It then writes an operation code that starts exactly one transfer. A write transfer sends one data byte to one sensor register. A read transfer fetches one sensor register into a result register.

The host polls a status register. It reads zero while the transfer runs, then a direction-specific completion code. Opcodes that are refused leave an error code instead, and no bus activity takes place. SCL and SDA are open-drain: the block only ever pulls a line low or releases it. SCL timing comes from a divider of the system clock.

Top module: `sccb_reg_bridge`

## Requirements
- R1: The window sits at `BASE_ADDR` (default 0x200) and is decoded on `busAddr[3:0]`: operation +0, status +1, enable +2, slave address +3, write index +4, write data +5, read index +8, read result +9. Other offsets and the operation register read 0x00. After reset: status 0x00, enable 0x00, slave address 0x60, all index, data and result registers 0x00, and both lines released.
- R2: Writing 0x05 to the operation register while enabled runs this sequence: start, slave address with bit 0 clear, write index byte, write data byte, stop. Status then reads 0x04.
- R3: Writing 0x70 while enabled runs two cycles. The first is start, slave address with bit 0 clear, read index byte, stop. The second is start, slave address with bit 0 set, one byte clocked in from the sensor with the master releasing SDA on the ninth clock (NACK), stop. The received byte is placed in the read result register and status reads 0x01.
- R4: Status reads 0x00 from the clock edge that accepts an opcode until the transfer completes.
- R5: When the enable register holds 0x00 or 0x01, any opcode write starts no bus activity and sets status to 0x80.
- R6: The address byte on the bus is the slave address register content. The acknowledge slot is not checked, so a transfer to an absent device still completes normally, and a read then returns 0xFF.
- R7: With the bus enabled, any opcode other than 0x05 and 0x70 starts nothing and sets status to 0x82.
- R8: Completion and error codes stay in the status register until the next accepted opcode write. Writes to other registers do not change them.
- R9: While a transfer runs, writes to the operation, enable, slave address, index and data registers are ignored.
- R10: SCL has a period of 4·Q system clocks, with Q = CLK_HZ/(4·SCL_HZ). Within each bit it is low for the first half and high for the second half.
- R11: SDA changes while SCL is high only to form a start (falling) or a stop (rising).
- R12: Every byte is shifted most significant bit first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | AW | Host register address |
| busWrEn | input | 1 | Host write strobe, one cycle per write |
| busWrData | input | 8 | Host write data |
| busRdData | output | 8 | Host read data, combinational from `busAddr` |
| sdaIn | input | 1 | Level sensed on the SDA line |
| sclDrvLow | output | 1 | Pull SCL low when 1, release when 0 |
| sdaDrvLow | output | 1 | Pull SDA low when 1, release when 0 |

## Verification
A sequencer that skips or repeats a step shows up on the lines at once. The sensor model then counts a wrong number of starts or stops, or captures a shifted byte. The status register stays at 0x00 or flips to the wrong completion code within one transaction, about thirty bit times. A corrupted shift register or bit counter changes the byte stored in the model, or the read result, by the end of the same transfer. A divider or phase fault changes the measured SCL rise-to-rise spacing within the first byte. It can also make SDA move while SCL is high, outside a start or stop.

// File: rtl/sccb_bridge_pkg.sv
package sccb_bridge_pkg;

  localparam logic [7:0] OP_WRITE   = 8'h05;
  localparam logic [7:0] OP_READ    = 8'h70;
  localparam logic [7:0] ST_BUSY    = 8'h00;
  localparam logic [7:0] ST_RD_OK   = 8'h01;
  localparam logic [7:0] ST_WR_OK   = 8'h04;
  localparam logic [7:0] ST_ERR_OFF = 8'h80;
  localparam logic [7:0] ST_ERR_OP  = 8'h82;

  typedef enum logic [1:0] {SDA_HOLD, SDA_REL, SDA_LOW, SDA_SHIFT} sdaMode_e;
  typedef enum logic [2:0] {LD_ADDR_W, LD_ADDR_R, LD_TX_IDX, LD_TX_VAL, LD_RX_IDX, LD_ONES} loadSel_e;
  typedef enum logic [1:0] {SEG_START, SEG_BYTE, SEG_STOP, SEG_DONE} seg_e;

  typedef struct packed {
    logic       sclLow;
    sdaMode_e   sdaMode;
    logic       load;
    loadSel_e   loadSel;
    logic       shift;
    logic       storeRx;
    logic       setStatus;
    logic [7:0] statusCode;
    logic       inByte;
  } strobe_t;

  // Segment kind for each step of a transaction
  function automatic seg_e segOf(input logic isRead, input logic [3:0] step);
    seg_e s;
    if (!isRead) begin
      case (step)
        4'd0:                s = SEG_START;
        4'd1, 4'd2, 4'd3:    s = SEG_BYTE;
        4'd4:                s = SEG_STOP;
        default:             s = SEG_DONE;
      endcase
    end else begin
      case (step)
        4'd0, 4'd4:                s = SEG_START;
        4'd1, 4'd2, 4'd5, 4'd6:    s = SEG_BYTE;
        4'd3, 4'd7:                s = SEG_STOP;
        default:                   s = SEG_DONE;
      endcase
    end
    return s;
  endfunction

  // Which byte a byte step shifts out
  function automatic loadSel_e selOf(input logic isRead, input logic [3:0] step);
    loadSel_e l;
    case (step)
      4'd1:    l = LD_ADDR_W;
      4'd2:    l = isRead ? LD_RX_IDX : LD_TX_IDX;
      4'd3:    l = LD_TX_VAL;
      4'd5:    l = LD_ADDR_R;
      default: l = LD_ONES;
    endcase
    return l;
  endfunction

endpackage

// File: rtl/sccb_bridge_ctrl.sv
module sccb_bridge_ctrl
  import sccb_bridge_pkg::*;
#(
  parameter int QUARTER = 125
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       opWrite,
  input  logic [7:0] opCode,
  input  logic       busEnabled,
  output logic       busy,
  output strobe_t    strb
);

  localparam int QW = (QUARTER > 1) ? $clog2(QUARTER) : 1;
  localparam logic [QW-1:0] Q_LAST = QW'(QUARTER - 1);

  typedef enum logic [1:0] {S_IDLE, S_START, S_BYTE, S_STOP} state_e;

  state_e        state;
  logic [3:0]    step;
  logic          isRead;
  logic [1:0]    phase;
  logic [3:0]    bitCnt;
  logic [QW-1:0] qCnt;

  logic       tick, segEnd, opValid;
  logic [3:0] nextStep;
  seg_e       nextSeg;

  assign busy     = (state != S_IDLE);
  assign tick     = busy && (qCnt == Q_LAST);
  assign segEnd   = tick && (phase == 2'd3) && (state != S_BYTE || bitCnt == 4'd8);
  assign nextStep = step + 4'd1;
  assign nextSeg  = segOf(isRead, nextStep);
  assign opValid  = (opCode == OP_WRITE) || (opCode == OP_READ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      step   <= '0;
      isRead <= 1'b0;
      phase  <= '0;
      bitCnt <= '0;
      qCnt   <= '0;
    end else if (state == S_IDLE) begin
      qCnt  <= '0;
      phase <= '0;
      if (opWrite && busEnabled && opValid) begin
        state  <= S_START;
        step   <= '0;
        isRead <= (opCode == OP_READ);
        bitCnt <= '0;
      end
    end else begin
      qCnt <= tick ? '0 : qCnt + 1'b1;
      if (tick) phase <= phase + 2'd1;
      if (tick && phase == 2'd3 && state == S_BYTE && bitCnt != 4'd8)
        bitCnt <= bitCnt + 4'd1;
      if (segEnd) begin
        step   <= nextStep;
        bitCnt <= '0;
        case (nextSeg)
          SEG_START: state <= S_START;
          SEG_BYTE:  state <= S_BYTE;
          SEG_STOP:  state <= S_STOP;
          default:   state <= S_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    strb            = '0;
    strb.sdaMode    = SDA_REL;
    strb.statusCode = ST_BUSY;
    strb.sclLow     = (state == S_BYTE || state == S_STOP) && (phase < 2'd2);
    strb.inByte     = (state == S_BYTE);
    case (state)
      S_START: strb.sdaMode = (phase < 2'd2) ? SDA_REL : SDA_LOW;
      S_BYTE:  strb.sdaMode = (phase == 2'd1) ? ((bitCnt == 4'd8) ? SDA_REL : SDA_SHIFT) : SDA_HOLD;
      S_STOP:  strb.sdaMode = (phase == 2'd0) ? SDA_HOLD : ((phase == 2'd3) ? SDA_REL : SDA_LOW);
      default: strb.sdaMode = SDA_REL;
    endcase
    strb.load    = segEnd && (nextSeg == SEG_BYTE);
    strb.loadSel = selOf(isRead, nextStep);
    strb.shift   = tick && state == S_BYTE && phase == 2'd2 && bitCnt < 4'd8;
    strb.storeRx = segEnd && isRead && step == 4'd6;
    if (state == S_IDLE && opWrite) begin
      strb.setStatus  = 1'b1;
      strb.statusCode = !busEnabled ? ST_ERR_OFF : (opValid ? ST_BUSY : ST_ERR_OP);
    end else if (segEnd && nextSeg == SEG_DONE) begin
      strb.setStatus  = 1'b1;
      strb.statusCode = isRead ? ST_RD_OK : ST_WR_OK;
    end
  end

  AST_OFF_NO_START: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && opWrite && !busEnabled) |=> !busy) else $error("disabled bus started"); // R5
  AST_BAD_OP_NO_START: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && opWrite && !opValid) |=> !busy) else $error("bad opcode started"); // R7
  AST_BIT_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= 4'd8) else $error("bit counter overrun"); // R12

endmodule

// File: rtl/sccb_bridge_dp.sv
module sccb_bridge_dp
  import sccb_bridge_pkg::*;
#(
  parameter int             AW          = 10,
  parameter logic [AW-1:0]  BASE_ADDR   = 10'h200,
  parameter logic [7:0]     RESET_SLAVE = 8'h60
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] busAddr,
  input  logic          busWrEn,
  input  logic [7:0]    busWrData,
  output logic [7:0]    busRdData,
  input  logic          sdaIn,
  input  logic          busy,
  input  strobe_t       strb,
  output logic          opWrite,
  output logic [7:0]    opCode,
  output logic          busEnabled,
  output logic          sclDrvLow,
  output logic          sdaDrvLow
);

  localparam logic [3:0] OFF_OP = 4'h0, OFF_STAT = 4'h1, OFF_EN = 4'h2, OFF_SLV = 4'h3;
  localparam logic [3:0] OFF_TXI = 4'h4, OFF_TXV = 4'h5, OFF_RXI = 4'h8, OFF_RXV = 4'h9;

  logic [7:0] enReg, slaveReg, txIdx, txVal, rxIdx, rxVal, statusReg, shiftReg;
  logic       hit, cfgWr, inByteQ;
  logic [3:0] off;

  assign off        = busAddr[3:0];
  assign hit        = (busAddr[AW-1:4] == BASE_ADDR[AW-1:4]);
  assign cfgWr      = busWrEn && hit && !busy;
  assign opWrite    = busWrEn && hit && (off == OFF_OP);
  assign opCode     = busWrData;
  assign busEnabled = (enReg[7:1] != 7'd0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg     <= '0;
      slaveReg  <= RESET_SLAVE;
      txIdx     <= '0;
      txVal     <= '0;
      rxIdx     <= '0;
      rxVal     <= '0;
      statusReg <= ST_BUSY;
      shiftReg  <= '0;
      sclDrvLow <= 1'b0;
      sdaDrvLow <= 1'b0;
      inByteQ   <= 1'b0;
    end else begin
      if (cfgWr) begin
        case (off)
          OFF_EN:  enReg    <= busWrData;
          OFF_SLV: slaveReg <= busWrData;
          OFF_TXI: txIdx    <= busWrData;
          OFF_TXV: txVal    <= busWrData;
          OFF_RXI: rxIdx    <= busWrData;
          default: ;
        endcase
      end
      if (strb.setStatus) statusReg <= strb.statusCode;
      if (strb.storeRx)   rxVal     <= shiftReg;
      if (strb.load) begin
        case (strb.loadSel)
          LD_ADDR_W: shiftReg <= {slaveReg[7:1], 1'b0};
          LD_ADDR_R: shiftReg <= {slaveReg[7:1], 1'b1};
          LD_TX_IDX: shiftReg <= txIdx;
          LD_TX_VAL: shiftReg <= txVal;
          LD_RX_IDX: shiftReg <= rxIdx;
          default:   shiftReg <= 8'hFF;
        endcase
      end else if (strb.shift) begin
        shiftReg <= {shiftReg[6:0], sdaIn};
      end
      sclDrvLow <= strb.sclLow;
      inByteQ   <= strb.inByte;
      case (strb.sdaMode)
        SDA_REL:   sdaDrvLow <= 1'b0;
        SDA_LOW:   sdaDrvLow <= 1'b1;
        SDA_SHIFT: sdaDrvLow <= ~shiftReg[7];
        default:   ;
      endcase
    end
  end

  always_comb begin
    busRdData = 8'h00;
    if (hit) begin
      case (off)
        OFF_STAT: busRdData = statusReg;
        OFF_EN:   busRdData = enReg;
        OFF_SLV:  busRdData = slaveReg;
        OFF_TXI:  busRdData = txIdx;
        OFF_TXV:  busRdData = txVal;
        OFF_RXI:  busRdData = rxIdx;
        OFF_RXV:  busRdData = rxVal;
        default:  busRdData = 8'h00;
      endcase
    end
  end

  AST_BUSY_STATUS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> statusReg == ST_BUSY) else $error("status nonzero while busy"); // R4
  AST_DONE_CODE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busy) && !busy) |-> (statusReg == ST_WR_OK || statusReg == ST_RD_OK)) else $error("bad completion code"); // R2
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> ($stable(txIdx) && $stable(txVal) && $stable(rxIdx) && $stable(slaveReg) && $stable(enReg))) else $error("config changed while busy"); // R9
  AST_SDA_STILL_SCL_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (inByteQ && $past(inByteQ) && !sclDrvLow && !$past(sclDrvLow)) |-> $stable(sdaDrvLow)) else $error("data moved with SCL high"); // R11

endmodule

// File: rtl/sccb_reg_bridge.sv
module sccb_reg_bridge
  import sccb_bridge_pkg::*;
#(
  parameter int             CLK_HZ      = 50_000_000,
  parameter int             SCL_HZ      = 100_000,
  parameter int             AW          = 10,
  parameter logic [AW-1:0]  BASE_ADDR   = 10'h200,
  parameter logic [7:0]     RESET_SLAVE = 8'h60
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] busAddr,
  input  logic          busWrEn,
  input  logic [7:0]    busWrData,
  output logic [7:0]    busRdData,
  input  logic          sdaIn,
  output logic          sclDrvLow,
  output logic          sdaDrvLow
);

  localparam int QRAW    = CLK_HZ / (4 * SCL_HZ);
  localparam int QUARTER = (QRAW < 1) ? 1 : QRAW;

  strobe_t    strb;
  logic       busy, opWrite, busEnabled;
  logic [7:0] opCode;

  sccb_bridge_ctrl #(.QUARTER(QUARTER)) ctrl_i (
    .clk(clk), .rstN(rstN), .opWrite(opWrite), .opCode(opCode),
    .busEnabled(busEnabled), .busy(busy), .strb(strb)
  );

  sccb_bridge_dp #(.AW(AW), .BASE_ADDR(BASE_ADDR), .RESET_SLAVE(RESET_SLAVE)) dp_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .sdaIn(sdaIn), .busy(busy),
    .strb(strb), .opWrite(opWrite), .opCode(opCode), .busEnabled(busEnabled),
    .sclDrvLow(sclDrvLow), .sdaDrvLow(sdaDrvLow)
  );

endmodule

// File: tb/sccb_reg_bridge_tb.sv
module sccb_reg_bridge_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int QUARTER    = 4;
  localparam logic [9:0] BASE = 10'h200;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [9:0] busAddr = BASE;
  logic       busWrEn = 1'b0;
  logic [7:0] busWrData = 8'h00;
  logic [7:0] busRdData;
  logic       sclDrvLow, sdaDrvLow;
  logic       slvLow = 1'b0;
  wire        sclBus = ~sclDrvLow;
  wire        sdaBus = ~(sdaDrvLow | slvLow);

  int checks = 0, bad = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sccb_reg_bridge #(.CLK_HZ(400), .SCL_HZ(25), .AW(10), .BASE_ADDR(BASE), .RESET_SLAVE(8'h60)) dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdData(busRdData), .sdaIn(sdaBus), .sclDrvLow(sclDrvLow), .sdaDrvLow(sdaDrvLow)
  );

  // sensor model, sampled on the falling system clock edge
  logic [7:0] mem [256];
  logic       prevScl = 1'b1, prevSda = 1'b1;
  int         sBit = 0, sByte = 0, lastRise = 0;
  int         startCnt = 0, stopCnt = 0, hiChanges = 0, gapBad = 0;
  logic [7:0] sSh = 0, sPtr = 0, lastAddrByte = 0;
  logic       sRd = 0, sMatch = 0;

  always @(negedge clk) begin
    if (sclBus && prevScl && (sdaBus != prevSda)) hiChanges++;
    if (sclBus && prevScl && prevSda && !sdaBus) begin
      startCnt++; sBit = 0; sByte = 0; slvLow <= 1'b0;
    end else if (sclBus && prevScl && !prevSda && sdaBus) begin
      stopCnt++;
    end else if (sclBus && !prevScl) begin
      if (sBit > 0 && (cyc - lastRise) != 4*QUARTER) gapBad++;
      lastRise = cyc;
      if (sBit < 8) sSh = {sSh[6:0], sdaBus};
      if (sBit == 7) begin
        if (sByte == 0) begin
          sRd = sSh[0]; sMatch = (sSh[7:1] == 7'h30); lastAddrByte = sSh;
        end else if (sByte == 1 && !sRd) sPtr = sSh;
        else if (sByte == 2 && !sRd && sMatch) mem[sPtr] = sSh;
      end
      if (sBit == 8) begin sBit = 0; sByte++; end else sBit++;
    end else if (!sclBus && prevScl) begin
      if (sRd && sMatch && sByte == 1 && sBit < 8) slvLow <= ~mem[sPtr][7 - sBit];
      else slvLow <= 1'b0;
    end
    prevScl = sclBus; prevSda = sdaBus;
  end

  function automatic logic [7:0] expStatus(input logic [7:0] en, input logic [7:0] op);
    if (en <= 8'h01)     return 8'h80;
    else if (op == 8'h05) return 8'h04;
    else if (op == 8'h70) return 8'h01;
    else                  return 8'h82;
  endfunction

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] off, input logic [7:0] d);
    @(negedge clk); busAddr = BASE + 10'(off); busWrData = d; busWrEn = 1'b1;
    @(negedge clk); busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] off, output logic [7:0] d);
    @(negedge clk); busAddr = BASE + 10'(off); #1; d = busRdData;
  endtask

  task automatic waitDone(output logic [7:0] st);
    st = 8'h00;
    for (int i = 0; i < 4000; i++) begin
      rd(4'h1, st);
      if (st != 8'h00) break;
    end
  endtask

  task automatic doWrite(input logic [7:0] idx, input logic [7:0] val, input string tag);
    logic [7:0] st; int s0;
    s0 = startCnt;
    wr(4'h4, idx); wr(4'h5, val); wr(4'h0, 8'h05);
    rd(4'h1, st); check(st == 8'h00, "R4 busy status", st, 0);
    waitDone(st);
    check(st == 8'h04, {tag, " write status"}, st, 8'h04);
    check(mem[idx] == val, {tag, " R12 stored byte"}, mem[idx], val);
    check(startCnt - s0 == 1, {tag, " R2 start count"}, startCnt - s0, 1);
  endtask

  task automatic doRead(input logic [7:0] idx, input string tag);
    logic [7:0] st, got, exp; int s0;
    s0 = startCnt; exp = mem[idx];
    wr(4'h8, idx); wr(4'h0, 8'h70);
    waitDone(st);
    check(st == 8'h01, {tag, " read status"}, st, 8'h01);
    rd(4'h9, got);
    check(got == exp, {tag, " R12 read byte"}, got, exp);
    check(startCnt - s0 == 2, {tag, " R3 start count"}, startCnt - s0, 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("  test done: total=%0d bad=%0d", checks + 1, bad);
    $finish;
  end

  initial begin
    logic [7:0] v, st;
    int s0, p0;
    for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + 11) ^ (i >> 2));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    rd(4'h1, v); check(v == 8'h00, "R1 status reset", v, 0);
    rd(4'h2, v); check(v == 8'h00, "R1 enable reset", v, 0);
    rd(4'h3, v); check(v == 8'h60, "R1 slave reset", v, 8'h60);
    rd(4'h9, v); check(v == 8'h00, "R1 result reset", v, 0);
    check(!sclDrvLow && !sdaDrvLow, "R1 lines released", {sclDrvLow, sdaDrvLow}, 0);
    // R5 disabled bus
    s0 = startCnt;
    wr(4'h0, 8'h05); repeat (40) @(negedge clk);
    rd(4'h1, v); check(v == expStatus(8'h00, 8'h05), "R5 disabled status", v, 8'h80);
    wr(4'h2, 8'h01); wr(4'h0, 8'h70); repeat (40) @(negedge clk);
    rd(4'h1, v); check(v == 8'h80, "R5 enable 0x01 status", v, 8'h80);
    check(startCnt == s0, "R5 no bus activity", startCnt - s0, 0);
    // R8 status kept across other writes
    wr(4'h4, 8'h33); rd(4'h1, v); check(v == 8'h80, "R8 status held", v, 8'h80);
    wr(4'h2, 8'h1E);
    rd(4'h2, v); check(v == 8'h1E, "R1 enable readback", v, 8'h1E);
    // R2 / R3 directed
    doWrite(8'h12, 8'h80, "R2 directed");
    check(lastAddrByte == 8'h60, "R6 write address byte", lastAddrByte, 8'h60);
    doRead(8'h12, "R3 directed");
    check(lastAddrByte == 8'h61, "R6 read address byte", lastAddrByte, 8'h61);
    check(startCnt == stopCnt, "R3 stop count", stopCnt, startCnt);
    // R7 bad opcode, R8 hold
    s0 = startCnt;
    wr(4'h0, 8'h33); repeat (40) @(negedge clk);
    rd(4'h1, v); check(v == expStatus(8'h1E, 8'h33), "R7 bad opcode status", v, 8'h82);
    check(startCnt == s0, "R7 no bus activity", startCnt - s0, 0);
    wr(4'h5, 8'h44); rd(4'h1, v); check(v == 8'h82, "R8 error held", v, 8'h82);
    // R9 writes while busy ignored
    wr(4'h4, 8'h20); wr(4'h5, 8'h5A); wr(4'h0, 8'h05);
    wr(4'h4, 8'h21); wr(4'h5, 8'hA5); wr(4'h0, 8'h70);
    waitDone(st);
    check(st == 8'h04, "R9 opcode ignored while busy", st, 8'h04);
    rd(4'h4, v); check(v == 8'h20, "R9 index kept", v, 8'h20);
    check(mem[8'h20] == 8'h5A, "R9 original data stored", mem[8'h20], 8'h5A);
    // R6 absent device
    wr(4'h3, 8'h42);
    p0 = int'(mem[8'h07]);
    wr(4'h4, 8'h07); wr(4'h5, 8'hC3); wr(4'h0, 8'h05); waitDone(st);
    check(st == 8'h04, "R6 absent device completes", st, 8'h04);
    check(int'(mem[8'h07]) == p0, "R6 absent device untouched", mem[8'h07], p0);
    wr(4'h8, 8'h07); wr(4'h0, 8'h70); waitDone(st);
    rd(4'h9, v); check(v == 8'hFF, "R6 absent device reads ones", v, 8'hFF);
    wr(4'h3, 8'h60);
    // corner data values
    doWrite(8'h00, 8'h00, "R12 zeros");
    doWrite(8'hFF, 8'hFF, "R12 ones");
    doRead(8'hFF, "R12 ones");
    // constrained random mix
    void'($urandom(32'd1234));
    for (int n = 0; n < 30; n++) begin
      logic [7:0] idx, val;
      idx = 8'($urandom); val = 8'($urandom);
      if ($urandom % 2 == 0) doWrite(idx, val, "R2 random");
      else doRead(idx, "R3 random");
    end
    check(gapBad == 0, "R10 SCL period", gapBad, 0);
    check(hiChanges == startCnt + stopCnt, "R11 SDA moves with SCL high", hiChanges, startCnt + stopCnt);
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule